// File: doc/BRIEF.md
# Page/Block Erasable Memory Array

This block is a small register-built storage array that follows the rules of page-and-block flash. Storage is split into blocks. Each block holds a fixed number of pages. Each page has a data area followed directly by a spare area, and both are reached through one byte offset.

Software places bytes into a page buffer one at a time. A program command then merges the buffer into a chosen page. Programming can only clear bits. A page may be programmed once between erases. Erasing works only on a whole block, and it restores every data byte and every spare byte of that block to 0xFF.

Reads return one byte per command. Program and erase each occupy the array for a fixed number of cycles. While the array is occupied, commands are dropped. A status output reports whether the most recent program command was refused.

Top module: `nand_page_array`

## Requirements
- R1: After reset, `ready` is 1, `prog_err` is 0, and every data and spare byte of every page reads 0xFF.
- R2: A read command (`cmd_op` = 0) accepted at a clock edge raises `rd_valid` for one cycle after that edge, with `rd_data` holding the byte at `cmd_off` of the addressed page. Offsets 0 to DBYTES-1 are data and DBYTES to DBYTES+SBYTES-1 are spare. Any larger offset reads 0xFF.
- R3: A load command (`cmd_op` = 1) writes `cmd_data` into the page buffer at `cmd_off`, and a load whose offset lies past the spare area has no effect. The buffer is all 0xFF after reset, after every completed program and after every refused program, so a byte that is not loaded leaves its page byte unchanged.
- R4: A program command (`cmd_op` = 2) to a page not yet written since its last erase drops `ready` for exactly PROG_CYC cycles. Each of the page's data and spare bytes then becomes its old value AND the buffer byte, the page is marked written, and `prog_err` reads 0.
- R5: A program command to a page already written since its block was last erased is refused. `ready` stays 1, `prog_err` reads 1 from the next cycle, and the page contents do not change.
- R6: An erase command (`cmd_op` = 3) drops `ready` for exactly ERASE_CYC cycles. It then sets every data and spare byte of every page in the addressed block to 0xFF and clears the written marks of those pages. Other blocks are left untouched.
- R7: While `ready` is 0, every incoming command is ignored. A read gives no `rd_valid`, a load leaves the buffer alone, and a program or erase starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 load, 2 program, 3 erase |
| cmd_blk | input | BW (2) | Block index |
| cmd_page | input | PW (2) | Page index within the block |
| cmd_off | input | OW (6) | Byte offset within the page, spare area after the data |
| cmd_data | input | 8 | Byte for a load command |
| ready | output | 1 | 1 when no program or erase is in progress |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | 8 | Byte returned by a read |
| prog_err | output | 1 | 1 when the last program command was refused |

## Verification
The program path is tested with several buffer patterns: a page with all 40 bytes loaded, a page with a few scattered loads, and a page with only the spare bytes loaded. Each of these separates correct per-byte merging and offset decoding from bytes that land at the wrong place or that miss the spare area. Reprogramming the same page before and after an erase separates the once-only rule from the state of the written mark. Stray read, load and program commands sent during an erase show whether commands really are ignored while busy. Reading a neighbouring block after an erase shows whether the erase stayed inside its block.

// File: rtl/nand_pkg.sv
package nand_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } nand_op_e;

  // flat cell number of (block, page, offset)
  function automatic int cell_index(int blk, int page, int off, int npage, int psize);
    return (blk * npage + page) * psize + off;
  endfunction

  // a program can only pull bits low
  function automatic logic [7:0] prog_merge(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction
endpackage

// File: rtl/nand_seq.sv
module nand_seq import nand_pkg::*; #(
  parameter int BW = 2,
  parameter int PW = 2,
  parameter int PROG_CYC = 5,
  parameter int ERASE_CYC = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  nand_op_e      op,
  input  logic [BW-1:0] blk,
  input  logic [PW-1:0] page,
  input  logic          page_written,
  output logic          busy,
  output logic          do_prog,
  output logic          do_erase,
  output logic          reject,
  output logic [BW-1:0] tgt_blk,
  output logic [PW-1:0] tgt_page,
  output logic          prog_err
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          mode_erase;
  logic          is_prog, start_prog, start_erase, done;

  assign is_prog     = accept && (op == OP_PROG);
  assign reject      = is_prog && page_written;
  assign start_prog  = is_prog && !page_written;
  assign start_erase = accept && (op == OP_ERASE);
  assign done        = busy && (cnt == '0);
  assign do_prog     = done && !mode_erase;
  assign do_erase    = done && mode_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      mode_erase <= 1'b0;
      tgt_blk    <= '0;
      tgt_page   <= '0;
      prog_err   <= 1'b0;
    end else if (start_prog) begin
      busy       <= 1'b1;
      cnt        <= CW'(PROG_CYC - 1);
      mode_erase <= 1'b0;
      tgt_blk    <= blk;
      tgt_page   <= page;
      prog_err   <= 1'b0;
    end else if (start_erase) begin
      busy       <= 1'b1;
      cnt        <= CW'(ERASE_CYC - 1);
      mode_erase <= 1'b1;
      tgt_blk    <= blk;
      tgt_page   <= page;
    end else if (reject) begin
      prog_err <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R4 R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == CW'($past(cnt) - 1'b1)));

  // R5
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!busy && prog_err));
endmodule

// File: rtl/nand_pgbuf.sv
module nand_pgbuf #(
  parameter int PSIZE = 40,
  parameter int OW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [OW-1:0]     load_off,
  input  logic [7:0]        load_data,
  input  logic              clear,
  output logic [PSIZE*8-1:0] buf_flat
);
  logic [7:0] bq [PSIZE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PSIZE; i++) bq[i] <= 8'hFF;
    end else if (clear) begin
      for (int i = 0; i < PSIZE; i++) bq[i] <= 8'hFF;
    end else if (load_en && (int'(load_off) < PSIZE)) begin
      bq[int'(load_off)] <= load_data;
    end
  end

  for (genvar g = 0; g < PSIZE; g++) begin : g_flat
    assign buf_flat[g*8 +: 8] = bq[g];
  end

  // R3
  clear_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (&buf_flat));
endmodule

// File: rtl/nand_store.sv
module nand_store import nand_pkg::*; #(
  parameter int NBLK = 4,
  parameter int NPAGE = 4,
  parameter int PSIZE = 40,
  parameter int BW = 2,
  parameter int PW = 2,
  parameter int OW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [BW-1:0]      q_blk,
  input  logic [PW-1:0]      q_page,
  input  logic [OW-1:0]      q_off,
  output logic               page_written,
  input  logic               do_prog,
  input  logic               do_erase,
  input  logic [BW-1:0]      tgt_blk,
  input  logic [PW-1:0]      tgt_page,
  input  logic [PSIZE*8-1:0] buf_flat,
  output logic               rd_valid,
  output logic [7:0]         rd_data
);
  localparam int NPG = NBLK * NPAGE;
  localparam int NCELL = NPG * PSIZE;

  logic [7:0]     mem [NCELL];
  logic [NPG-1:0] wr_q;
  int             q_pidx, tgt_pidx, pbase, ebase;

  assign q_pidx   = int'(q_blk) * NPAGE + int'(q_page);
  assign tgt_pidx = int'(tgt_blk) * NPAGE + int'(tgt_page);
  assign pbase    = cell_index(int'(tgt_blk), int'(tgt_page), 0, NPAGE, PSIZE);
  assign ebase    = int'(tgt_blk) * NPAGE;
  assign page_written = wr_q[q_pidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) mem[i] <= 8'hFF;
      wr_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 8'hFF;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= (int'(q_off) < PSIZE) ?
                   mem[cell_index(int'(q_blk), int'(q_page), int'(q_off), NPAGE, PSIZE)] : 8'hFF;
      if (do_prog) begin
        for (int i = 0; i < PSIZE; i++)
          mem[pbase + i] <= prog_merge(mem[pbase + i], buf_flat[i*8 +: 8]);
        wr_q[tgt_pidx] <= 1'b1;
      end
      if (do_erase) begin
        for (int i = 0; i < NPAGE * PSIZE; i++) mem[ebase * PSIZE + i] <= 8'hFF;
        for (int p = 0; p < NPAGE; p++) wr_q[ebase + p] <= 1'b0;
      end
    end
  end

  // R4
  prog_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> wr_q[$past(tgt_pidx)]);

  // R6
  erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_erase |=> (wr_q[$past(ebase) +: NPAGE] == '0));
endmodule

// File: rtl/nand_page_array.sv
module nand_page_array import nand_pkg::*; #(
  parameter int NBLK = 4,
  parameter int NPAGE = 4,
  parameter int DBYTES = 32,
  parameter int SBYTES = 8,
  parameter int PROG_CYC = 5,
  parameter int ERASE_CYC = 12,
  localparam int PSIZE = DBYTES + SBYTES,
  localparam int BW = $clog2(NBLK),
  localparam int PW = $clog2(NPAGE),
  localparam int OW = $clog2(PSIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_blk,
  input  logic [PW-1:0] cmd_page,
  input  logic [OW-1:0] cmd_off,
  input  logic [7:0]    cmd_data,
  output logic          ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          prog_err
);
  nand_op_e             op;
  logic                 accept, busy, rd_en, load_en, buf_clear;
  logic                 do_prog, do_erase, reject, page_written;
  logic [BW-1:0]        tgt_blk;
  logic [PW-1:0]        tgt_page;
  logic [PSIZE*8-1:0]   buf_flat;

  assign op        = nand_op_e'(cmd_op);
  assign accept    = cmd_valid && !busy;
  assign rd_en     = accept && (op == OP_READ);
  assign load_en   = accept && (op == OP_LOAD);
  assign buf_clear = do_prog || reject;
  assign ready     = !busy;

  nand_seq #(.BW(BW), .PW(PW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op), .blk(cmd_blk), .page(cmd_page),
    .page_written(page_written), .busy(busy), .do_prog(do_prog), .do_erase(do_erase),
    .reject(reject), .tgt_blk(tgt_blk), .tgt_page(tgt_page), .prog_err(prog_err)
  );

  nand_pgbuf #(.PSIZE(PSIZE), .OW(OW)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_off(cmd_off),
    .load_data(cmd_data), .clear(buf_clear), .buf_flat(buf_flat)
  );

  nand_store #(.NBLK(NBLK), .NPAGE(NPAGE), .PSIZE(PSIZE), .BW(BW), .PW(PW), .OW(OW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .q_blk(cmd_blk), .q_page(cmd_page),
    .q_off(cmd_off), .page_written(page_written), .do_prog(do_prog), .do_erase(do_erase),
    .tgt_blk(tgt_blk), .tgt_page(tgt_page), .buf_flat(buf_flat),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ready));
endmodule

// File: tb/tb_nand_page_array.sv
module tb_nand_page_array;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 4, NPAGE = 4, PSIZE = 40;
  localparam int PROG_CYC = 5, ERASE_CYC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0, cmd_blk = 2'd0, cmd_page = 2'd0;
  logic [5:0] cmd_off = 6'd0;
  logic [7:0] cmd_data = 8'd0;
  logic ready, rd_valid, prog_err;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  int expm [NBLK*NPAGE*PSIZE];
  int bbuf [PSIZE];

  nand_page_array #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_page(cmd_page), .cmd_off(cmd_off), .cmd_data(cmd_data), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .prog_err(prog_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int idx(int b, int p, int o);
    return b * NPAGE * PSIZE + p * PSIZE + o;
  endfunction

  function automatic int pat(int o, int seed);
    return ((o * 37 + 11 + seed) & 255) ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic issue(int op, int b, int p, int o, int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_blk = 2'(b); cmd_page = 2'(p);
    cmd_off = 6'(o); cmd_data = 8'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(int b, int p, int o, int e, string req);
    issue(0, b, p, o, 0);
    chk(rd_valid == 1'b1 && int'(rd_data) == e, req, rd_valid ? int'(rd_data) : 'h100, e);
  endtask

  task automatic check_page(int b, int p, string req);
    for (int o = 0; o < PSIZE; o++) rd_chk(b, p, o, expm[idx(b, p, o)], req);
  endtask

  task automatic load(int o, int d);
    issue(1, 0, 0, o, d);
    if (o < PSIZE) bbuf[o] = d;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic prog(int b, int p, bit expect_rej);
    int n;
    issue(2, b, p, 0, 0);
    if (expect_rej) begin
      chk(ready == 1'b1, "R5 ready stays high", ready, 1);
      chk(prog_err == 1'b1, "R5 prog_err set", prog_err, 1);
    end else begin
      wait_busy(n);
      chk(n == PROG_CYC, "R4 program busy length", n, PROG_CYC);
      chk(prog_err == 1'b0, "R4 prog_err clear", prog_err, 0);
      for (int o = 0; o < PSIZE; o++) expm[idx(b, p, o)] &= bbuf[o];
    end
    for (int o = 0; o < PSIZE; o++) bbuf[o] = 8'hFF;
  endtask

  task automatic erase(int b);
    int n;
    issue(3, b, 0, 0, 0);
    wait_busy(n);
    chk(n == ERASE_CYC, "R6 erase busy length", n, ERASE_CYC);
    for (int i = 0; i < NPAGE * PSIZE; i++) expm[b * NPAGE * PSIZE + i] = 8'hFF;
  endtask

  task automatic t_reset;
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(prog_err == 1'b0, "R1 prog_err after reset", prog_err, 0);
    rd_chk(0, 0, 0, 8'hFF, "R1 erased byte");
    rd_chk(3, 3, 39, 8'hFF, "R1 erased spare");
    rd_chk(1, 2, 32, 8'hFF, "R1 erased spare start");
  endtask

  task automatic t_prog_full;
    for (int o = 0; o < PSIZE; o++) load(o, pat(o, 0));
    prog(1, 2, 0);
    check_page(1, 2, "R2 R4 full page with spare");
  endtask

  task automatic t_reject;
    load(0, 0); load(33, 0);
    prog(1, 2, 1);
    check_page(1, 2, "R5 page unchanged after refusal");
  endtask

  task automatic t_offrange;
    rd_chk(1, 2, 45, 8'hFF, "R2 offset past spare");
    rd_chk(1, 2, 63, 8'hFF, "R2 top offset");
    load(50, 0);
  endtask

  task automatic t_erase_reuse;
    erase(1);
    check_page(1, 2, "R6 block wiped incl spare");
    prog(1, 2, 0);
    check_page(1, 2, "R3 buffer cleared after refusal");
  endtask

  task automatic t_scatter_and_isolation;
    load(3, 8'h0F); load(20, 8'hA5); load(36, 8'h00);
    prog(2, 0, 0);
    check_page(2, 0, "R4 scattered loads");
    for (int o = 32; o < PSIZE; o++) load(o, pat(o, 5));
    prog(3, 3, 0);
    check_page(3, 3, "R4 spare only");
    erase(1);
    check_page(2, 0, "R6 other block kept");
    check_page(3, 3, "R6 other block kept spare");
  endtask

  task automatic t_busy_ignore;
    int n;
    issue(3, 2, 0, 0, 0);
    chk(ready == 1'b0, "R7 busy during erase", ready, 0);
    issue(0, 1, 2, 0, 0);
    chk(rd_valid == 1'b0, "R7 read ignored", rd_valid, 0);
    issue(1, 0, 0, 5, 0);
    issue(2, 0, 0, 0, 0);
    chk(ready == 1'b0, "R7 still busy", ready, 0);
    wait_busy(n);
    for (int i = 0; i < NPAGE * PSIZE; i++) expm[2 * NPAGE * PSIZE + i] = 8'hFF;
    check_page(2, 0, "R6 erase wipes programmed page");
    prog(0, 0, 0);
    check_page(0, 0, "R7 load and program ignored while busy");
    check_page(1, 2, "R6 neighbour block untouched");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBLK*NPAGE*PSIZE; i++) expm[i] = 8'hFF;
    for (int o = 0; o < PSIZE; o++) bbuf[o] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prog_full;
    t_reject;
    t_offrange;
    t_erase_reuse;
    t_scatter_and_isolation;
    t_busy_ignore;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule